// File: doc/BRIEF.md
# PWM Input Period and High-Time Capture

This block measures an external pulse-width-modulated waveform. A prescaled up-counter provides a time base, and the waveform is timestamped against it. A select input picks one of two pins as the source. That source feeds two capture units at the same time. The rising-edge unit records counter values on rising edges, and the falling-edge unit records them on falling edges.

After a start strobe, the first rising capture fixes a reference stamp. The second rising capture closes the window. At that moment the block takes the falling-edge unit's latest stamp. It then computes two values in counter ticks:

- **Period:** the span between the two rising stamps.
- **High time:** the span from the first rising stamp to the falling stamp.

Both values are presented together with a one-cycle done pulse.

An edge divider can make both units capture only on every 2nd, 4th or 8th qualifying edge. This stretches the measured window over several input periods so that fast signals can still be resolved. The caller converts ticks to time from its own knowledge of the clock and the divider settings. A tick timeout aborts a measurement that never completes.

Top module: `pwm_cap`

## Requirements
- R1: After reset, `period_o` and `duty_o` are 0, and `done_o` and `err_o` are low.
- R2: With `src_sel_i`=0 the measured waveform is `pin_a_i`; with `src_sel_i`=1 it is `pin_b_i`. The unselected pin has no effect on any output.
- R3: Each pin transition is synchronized by two flops, and a third flop detects the edge. A transition first driven after clock edge E is stamped with the counter value held after edge E+2. With no counter wrap and edge divider code 0, `period_o` is the tick count between two consecutive rising edges. In the same case, `duty_o` is the tick count of the high phase between them.
- R4: A start strobe clears the counter. The counter then advances once every `psc_i`+1 clocks, so a stamp equals floor((E+2−S)/(`psc_i`+1)), where S is the edge that sampled start.
- R5: The counter counts from 0 to `cnt_max_i` and then returns to 0. The span from a reference stamp a to a later stamp b is b−a when b≥a. Otherwise it is `cnt_max_i`−a+b.
- R6: If the computed high time exceeds the computed period, one period is subtracted from the high time.
- R7: The 2-bit `edge_div_i` code k selects capture on every 2^k-th qualifying edge (every 1st, 2nd, 4th or 8th). The same code applies to both units. Edge counts restart at start. `period_o` then spans 2^k input periods.
- R8: When k>0 and the high time is at least (period >> k), the high time is replaced by (period >> k) − (period − high time), computed modulo 2^`CNT_W`.
- R9: `done_o` is a single-cycle pulse. It rises four clocks after the edge that completes the second rising capture is driven. Results hold until the next completed measurement, and no further capture occurs until the next start.
- R10: A nonzero `timeout_i` aborts the measurement after that many counter ticks without a second rising capture. On abort, `err_o` goes high and stays high, and no done pulse is produced. A value of 0 disables the timeout.
- R11: Start, even in the middle of a measurement, restarts the sequence from a cleared counter and clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; arms a new measurement |
| src_sel_i | input | 1 | Source select: 0 = pin A, 1 = pin B |
| pin_a_i | input | 1 | Waveform input A (asynchronous) |
| pin_b_i | input | 1 | Waveform input B (asynchronous) |
| psc_i | input | PSC_W | Counter clock prescaler; divide by value+1 |
| cnt_max_i | input | CNT_W | Counter maximum before wrap |
| edge_div_i | input | 2 | Edge divider code: every 1st/2nd/4th/8th edge |
| timeout_i | input | TO_W | Timeout in counter ticks; 0 disables |
| period_o | output | CNT_W | Measured period in ticks |
| duty_o | output | CNT_W | Measured high time in ticks |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Measurement aborted by timeout |

## Verification
The in-module assertions check the following on every cycle:

- the counter's return to zero after the maximum and its clearing on start;
- the counter holding still while idle;
- the edge divider's reload after a qualifying capture;
- the single-cycle width of edge pulses and of the done strobe;
- the ordering of error and done against start.

Only the bench's scenarios can show that the stamps, the wrap arithmetic, the over-period subtraction and the high-phase fix-up produce the right numbers. For this, the bench builds its own stamp model from the cycles at which it drives each pin transition. That model covers random periods, prescalers, divider codes and small counter maxima that force wraps and aliasing.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;
  localparam int EDIV_W = 3;

  // code k -> reload mask 2^k-1
  function automatic logic [EDIV_W-1:0] ediv_mask(input logic [1:0] code);
    logic [EDIV_W:0] one_hot;
    one_hot = (EDIV_W+1)'(1) << code;
    return EDIV_W'(one_hot - (EDIV_W+1)'(1));
  endfunction
endpackage

// File: rtl/pwm_cap_edge.sv
module pwm_cap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic pin_a_i,
  input  logic pin_b_i,
  output logic rise_o,
  output logic fall_o
);
  logic       pin;
  logic [1:0] sync_q;
  logic       prev_q;

  assign pin = sel_i ? pin_b_i : pin_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin};
      prev_q <= sync_q[1];
    end
  end

  assign rise_o = sync_q[1] & ~prev_q;
  assign fall_o = ~sync_q[1] & prev_q;

  a_r3_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r3_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pwm_cap_evdiv.sv
module pwm_cap_evdiv
  import pwm_cap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic       edge_i,
  input  logic [1:0] code_i,
  output logic       fire_o
);
  logic [EDIV_W-1:0] cnt_q;
  logic [EDIV_W-1:0] mask;
  logic              hit;

  assign mask   = ediv_mask(code_i);
  assign hit    = en_i & edge_i & ~clear_i;
  assign fire_o = hit && (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (hit)     cnt_q <= (cnt_q == mask) ? '0 : cnt_q + 1'b1;
  end

  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> cnt_q == '0);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_cap_timebase.sv
module pwm_cap_timebase #(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16,
  parameter int TO_W  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [PSC_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TO_W-1:0]  to_q;
  logic             tick;

  assign tick = run_i & (pre_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      to_q  <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
      cnt_q <= '0;
      to_q  <= '0;
    end else if (run_i) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        cnt_q <= (cnt_q >= max_i) ? '0 : cnt_q + 1'b1;
        to_q  <= to_q + 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = tick && (timeout_i != '0) && (to_q == timeout_i - TO_W'(1));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0) && (pre_q == '0));
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cnt_q));
  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && tick && cnt_q >= max_i) |=> cnt_q == '0);
endmodule

// File: rtl/pwm_cap_calc.sv
module pwm_cap_calc #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] t0_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] duty_o
);
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b,
                                            input logic [CNT_W-1:0] m);
    return (b >= a) ? b - a : m - a + b;
  endfunction

  logic [CNT_W-1:0] per, raw, fix, part;

  always_comb begin
    per  = span(t0_i, t2_i, max_i);
    raw  = span(t0_i, t1_i, max_i);
    fix  = (raw > per) ? raw - per : raw;   // falling stamp one period late
    part = per >> code_i;
    if (code_i != 2'd0 && fix >= part)      // window opened in high phase
      fix = part - (per - fix);
    period_o = per;
    duty_o   = fix;
  end
endmodule

// File: rtl/pwm_cap.sv
module pwm_cap #(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16,
  parameter int TO_W  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             src_sel_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] cnt_max_i,
  input  logic [1:0]       edge_div_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int N_UNIT = 2;   // 0: rising unit, 1: falling unit

  logic             rise, fall, expire;
  logic [N_UNIT-1:0] edges, fires;
  logic [CNT_W-1:0] cnt;
  logic             busy_q, got0_q, calc_q, done_q, err_q;
  logic [CNT_W-1:0] t0_q, t1_q, t2_q, cap2_q;
  logic [CNT_W-1:0] per_c, duty_c, per_q, duty_q;

  pwm_cap_edge u_edge (
    .clk_i, .rst_ni, .sel_i(src_sel_i), .pin_a_i, .pin_b_i,
    .rise_o(rise), .fall_o(fall)
  );

  pwm_cap_timebase #(.PSC_W(PSC_W), .CNT_W(CNT_W), .TO_W(TO_W)) u_tb (
    .clk_i, .rst_ni, .clear_i(start_i), .run_i(busy_q), .psc_i,
    .max_i(cnt_max_i), .timeout_i, .cnt_o(cnt), .expire_o(expire)
  );

  assign edges = {fall, rise};

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    pwm_cap_evdiv u_div (
      .clk_i, .rst_ni, .clear_i(start_i), .en_i(busy_q),
      .edge_i(edges[u]), .code_i(edge_div_i), .fire_o(fires[u])
    );
  end

  pwm_cap_calc #(.CNT_W(CNT_W)) u_calc (
    .t0_i(t0_q), .t1_i(t1_q), .t2_i(t2_q), .max_i(cnt_max_i),
    .code_i(edge_div_i), .period_o(per_c), .duty_o(duty_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      got0_q <= 1'b0;
      calc_q <= 1'b0;
      err_q  <= 1'b0;
      t0_q   <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      cap2_q <= '0;
    end else begin
      calc_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        got0_q <= 1'b0;
        err_q  <= 1'b0;
        cap2_q <= '0;
      end else if (busy_q) begin
        if (fires[1]) cap2_q <= cnt;
        if (fires[0]) begin
          if (!got0_q) begin
            t0_q   <= cnt;
            got0_q <= 1'b1;
          end else begin
            t1_q   <= cap2_q;
            t2_q   <= cnt;
            busy_q <= 1'b0;
            calc_q <= 1'b1;
          end
        end else if (expire) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      done_q <= calc_q;
      if (calc_q) begin
        per_q  <= per_c;
        duty_q <= duty_c;
      end
    end
  end

  assign period_o = per_q;
  assign duty_o   = duty_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_stopped_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(start_i)) |-> !busy_q);
  a_r10_err_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(busy_q));
  a_r10_no_done_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(start_i)) |-> !err_o);
  a_r11_start_clears_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !err_o);
endmodule

// File: tb/pwm_cap_test.sv
`timescale 1ns/1ps
module pwm_cap_test;
  localparam int PW = 16;
  localparam int CW = 16;
  localparam int TW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sel = 1'b0;
  logic          pin_a = 1'b0;
  logic          pin_b = 1'b0;
  logic [PW-1:0] psc = '0;
  logic [CW-1:0] cmax = '1;
  logic [1:0]    ediv = '0;
  logic [TW-1:0] tmo = '0;
  logic [CW-1:0] period, duty;
  logic          done, err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_cap uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_sel_i(sel),
    .pin_a_i(pin_a), .pin_b_i(pin_b), .psc_i(psc), .cnt_max_i(cmax),
    .edge_div_i(ediv), .timeout_i(tmo), .period_o(period), .duty_o(duty),
    .done_o(done), .err_o(err)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  task automatic cmp(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // selected pin gets the level, the other one random noise (R2)
  task automatic drive(input bit s, input bit lv);
    if (s) begin pin_b = lv; pin_a = 1'($urandom % 2); end
    else   begin pin_a = lv; pin_b = 1'($urandom % 2); end
  endtask

  function automatic logic [CW-1:0] stamp(input int c, input int cs, input int ps,
                                          input logic [CW-1:0] m);
    int tk;
    tk = (c - cs + 1) / (ps + 1);
    return CW'(tk % (int'(m) + 1));
  endfunction

  function automatic logic [CW-1:0] span(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                         input logic [CW-1:0] m);
    return (b >= a) ? CW'(b - a) : CW'(m - a + b);
  endfunction

  task automatic model_calc(input logic [CW-1:0] t0, input logic [CW-1:0] t1,
                            input logic [CW-1:0] t2, input logic [CW-1:0] m, input int k,
                            output logic [CW-1:0] p, output logic [CW-1:0] d);
    logic [CW-1:0] q;
    p = span(t0, t2, m);                         // R5
    d = span(t0, t1, m);
    if (d > p) d = CW'(d - p);                   // R6
    q = p >> k;
    if (k != 0 && d >= q) d = CW'(q - (p - d));  // R8
  endtask

  task automatic run_scn(input string tag, input bit s, input int ps, input logic [CW-1:0] m,
                         input int k, input int per, input int hi, input int off, input int rs_at);
    int cs, nr, nf, c2, dn_cnt, dn_cyc, since_chg, div, len;
    bit lv, lv_n, got0, mfin, restarted;
    logic [CW-1:0] m_t0, m_t1, m_t2, m_cap2, e_p, e_d, got_p, got_d;
    div = 1 << k;
    len = (2 * div + 3) * per + 30;
    @(negedge clk);
    sel = s; psc = PW'(ps); cmax = m; ediv = 2'(k); tmo = '0;
    lv = ((off % per) < hi);
    drive(s, lv);
    repeat (6) begin @(negedge clk); drive(s, lv); end
    start = 1'b1; cs = cyc;
    nr = 0; nf = 0; got0 = 0; mfin = 0; m_cap2 = '0; m_t0 = '0; m_t1 = '0; m_t2 = '0;
    c2 = -100; dn_cnt = 0; dn_cyc = 0; since_chg = 10; restarted = 0;
    got_p = '0; got_d = '0;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      if (done) begin
        dn_cnt++;
        if (dn_cnt == 1) begin dn_cyc = cyc; got_p = period; got_d = duty; end
      end
      lv_n = (((t + off) % per) < hi);
      if (rs_at > 0 && !restarted && t >= rs_at && lv_n == lv && since_chg >= 3) begin
        start = 1'b1; cs = cyc; restarted = 1;   // R11 restart mid-measurement
        nr = 0; nf = 0; got0 = 0; mfin = 0; m_cap2 = '0;
      end else begin
        start = 1'b0;
      end
      if (lv_n != lv) begin
        since_chg = 0;
        if (!mfin) begin
          if (lv_n) begin
            nr++;
            if (nr % div == 0) begin
              if (!got0) begin m_t0 = stamp(cyc, cs, ps, m); got0 = 1; end
              else begin m_t2 = stamp(cyc, cs, ps, m); m_t1 = m_cap2; c2 = cyc; mfin = 1; end
            end
          end else begin
            nf++;
            if (nf % div == 0) m_cap2 = stamp(cyc, cs, ps, m);
          end
        end
      end else begin
        since_chg++;
      end
      lv = lv_n;
      drive(s, lv);
    end
    model_calc(m_t0, m_t1, m_t2, m, k, e_p, e_d);
    cmp({tag, " R9 done count"}, dn_cnt, 1);
    cmp({tag, " R9 done latency"}, dn_cyc, c2 + 4);
    cmp({tag, " period"}, got_p, e_p);
    cmp({tag, " duty"}, got_d, e_d);
    repeat (5) @(negedge clk);
    cmp({tag, " R9 period hold"}, period, got_p);
  endtask

  task automatic run_timeout();
    int cs, dn;
    @(negedge clk);
    sel = 1'b0; psc = PW'(1); ediv = '0; cmax = '1; tmo = TW'(40);
    pin_a = 1'b0; pin_b = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; cs = cyc;
    @(negedge clk); start = 1'b0;
    dn = 0;
    while (cyc < cs + 70) begin @(negedge clk); if (done) dn++; end
    cmp("R10 err before expiry", err, 0);
    while (cyc < cs + 90) begin @(negedge clk); if (done) dn++; end
    cmp("R10 err after expiry", err, 1);
    cmp("R10 no done on abort", dn, 0);
    repeat (20) @(negedge clk);
    cmp("R10 err sticky", err, 1);
    tmo = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    cmp("R11 start clears err", err, 0);
    repeat (200) @(negedge clk);
    cmp("R10 zero timeout disabled", err, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    cmp("R1 reset period", period, 0);
    cmp("R1 reset duty", duty, 0);
    cmp("R1 reset done", done, 0);
    cmp("R1 reset err", err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1 idle done", done, 0);

    run_scn("R3 basic",        1'b0, 0, '1, 0, 20, 7, 5, 0);
    run_scn("R2 pin b",        1'b1, 0, '1, 0, 15, 4, 9, 0);
    run_scn("R4 prescale",     1'b0, 2, '1, 0, 30, 9, 3, 0);
    for (int o = 0; o < 3; o++)
      run_scn("R5 wrap",       1'b0, 0, CW'(25), 0, 20, 6, o * 4, 0);
    for (int o = 0; o < 6; o++)
      run_scn("R6 alias",      1'b0, 0, CW'(9), 0, 12, 3, o, 0);
    run_scn("R7 R8 high k2",   1'b0, 0, '1, 2, 16, 6, 0, 0);
    run_scn("R7 R8 high k1",   1'b1, 1, '1, 1, 14, 5, 2, 0);
    run_scn("R7 low k3",       1'b0, 0, '1, 3, 16, 6, 10, 0);
    run_scn("R11 restart",     1'b0, 0, '1, 0, 18, 5, 9, 3);
    run_timeout();

    for (int i = 0; i < 24; i++) begin
      int p, h, ps, k, off;
      bit s;
      logic [CW-1:0] m;
      s   = 1'($urandom % 2);
      ps  = $urandom % 4;
      k   = $urandom % 4;
      p   = 8 + $urandom % 33;
      h   = 3 + $urandom % (p - 5);
      off = $urandom % p;
      m   = ($urandom % 2 == 1) ? '1 : CW'(20 + $urandom % 200);
      run_scn("R2 R3 R4 R5 R6 R7 R8 random", s, ps, m, k, p, h, off, 0);
    end

    report();
    $finish;
  end
endmodule